// File: doc/BRIEF.md
# Frame Interrupt Coalescing Timer

This block sits between one direction of a network controller's frame engine (transmit or receive) and the interrupt logic. It holds back the frame interrupt so that the host is interrupted once per group of frames, not once per frame. A request is raised when a programmed number of frame events has built up, or when a programmed time has passed since the first event of the group, whichever happens first.

One 32-bit configuration word sets the block up. It carries an enable bit, an 8-bit frame-count threshold and a 16-bit time threshold. Time is measured in units of 64 interface clock periods. The interface clock reaches the block as a one-cycle clock-enable tick in the system clock domain. If coalescing is off, or either threshold is zero, every frame event raises the request at once. The request stays high until the host acknowledges it.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the configuration is enabled, with a count threshold of 16 and a time threshold of 768, and `irq` is low. With no ticks, 15 frame events leave `irq` low and the 16th raises it.
- R2: A `cfg_wr` pulse loads `cfg_wdata` in full. Bit 31 is the enable, bits 28:21 are the count threshold and bits 15:0 are the time threshold. All other bits are ignored.
- R3: When the enable bit is 0, or the count field is 0, or the time field is 0, the block is in bypass. Every `frame_done` then sets `irq` on the next clock edge.
- R4: With coalescing on and count threshold C, `irq` rises on the clock edge that samples the C-th frame event of the current window. Fewer events do not raise it.
- R5: With coalescing on and time threshold T, the window timer counts only cycles where `if_tick` is high. It starts on the edge that samples the first frame event of a window. `irq` rises on the edge that samples the 64*T-th tick after that edge.
- R6: Whichever of the count or the time condition is met first raises `irq`. Both the frame counter and the timer then clear, so the next window starts from zero.
- R7: Once set, `irq` stays high until an `irq_ack` cycle clears it on the next edge. If a new interrupt condition occurs in the same cycle as the acknowledge, `irq` stays high.
- R8: Frame events that arrive while `irq` is pending are counted toward a new window.
- R9: A configuration write clears the frame count and stops the timer.
- R10: A count threshold of 1 makes every frame event raise `irq` at once.
- R11: The timer does not run until a frame event has occurred. Ticks on their own never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (enable, count threshold, time threshold) |
| frame_done | input | 1 | One-cycle pulse for each completed frame |
| if_tick | input | 1 | Clock-enable, high for one cycle per interface clock |
| irq_ack | input | 1 | Host acknowledge; clears the pending request |
| irq | output | 1 | Coalesced interrupt request |

## Verification
The hardest case to reach from the ports is the time limit expiring at exactly the 64*T-th tick. Ticks are gated, so the expiry edge depends on which cycles carried a tick, not on elapsed cycles. The bench reaches this case by sending one frame and then driving ticks only on alternate cycles. It checks `irq` one tick before the expiry edge and again on that edge. The clearing of a window, whether by the timer, by a count hit or by a configuration rewrite, is only visible in later behaviour. The bench reaches it by sending a partial group after the clearing event and checking that the threshold is counted again from zero.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

   localparam int CFG_W    = 32;
   localparam int CNT_W    = 8;
   localparam int TIME_W   = 16;
   localparam int EN_BIT   = 31;
   localparam int CNT_LSB  = 21;
   localparam int TIME_LSB = 0;

   typedef struct packed {
      logic              en;
      logic [CNT_W-1:0]  cnt_thr;
      logic [TIME_W-1:0] time_thr;
   } coal_cfg_t;

   function automatic coal_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
      coal_cfg_t c;
      c.en       = w[EN_BIT];
      c.cnt_thr  = w[CNT_LSB +: CNT_W];
      c.time_thr = w[TIME_LSB +: TIME_W];
      return c;
   endfunction

   function automatic logic cfg_coalescing(input coal_cfg_t c);
      return c.en && (c.cnt_thr != '0) && (c.time_thr != '0);
   endfunction

endpackage

// File: rtl/irq_coal_cfg.sv
module irq_coal_cfg
   import irq_coal_pkg::*;
#(
   parameter bit                RST_EN   = 1'b1,
   parameter logic [CNT_W-1:0]  RST_CNT  = 8'd16,
   parameter logic [TIME_W-1:0] RST_TIME = 16'd768
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   output coal_cfg_t        cfg,
   output logic             active
);

   coal_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.en       <= RST_EN;
         cfg_q.cnt_thr  <= RST_CNT;
         cfg_q.time_thr <= RST_TIME;
      end else if (wr) begin
         cfg_q <= cfg_unpack(wdata);
      end
   end

   assign cfg    = cfg_q;
   assign active = cfg_coalescing(cfg_q);

endmodule

// File: rtl/irq_coal_counter.sv
module irq_coal_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] thr,
   output logic [W-1:0] cnt,
   output logic         hit
);

   logic [W-1:0] cnt_q;
   logic [W:0]   cnt_nxt;

   assign cnt_nxt = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
   assign hit     = inc && (cnt_nxt >= {1'b0, thr});
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (inc)    cnt_q <= cnt_nxt[W-1:0];
   end

endmodule

// File: rtl/irq_coal_timer.sv
module irq_coal_timer #(
   parameter int TW      = 16,
   parameter int PRESC_W = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          arm,
   input  logic          tick,
   input  logic [TW-1:0] thr,
   output logic          running,
   output logic          expire
);

   logic          run_q;
   logic [TW-1:0] units_q;
   logic [TW:0]   units_nxt;
   logic          unit_done;

   assign units_nxt = {1'b0, units_q} + {{TW{1'b0}}, 1'b1};
   assign running   = run_q;
   assign expire    = unit_done && (units_nxt == {1'b0, thr});

   generate
      if (PRESC_W == 0) begin : g_direct
         assign unit_done = run_q && tick;
      end else begin : g_presc
         localparam logic [PRESC_W-1:0] PMAX = {PRESC_W{1'b1}};
         logic [PRESC_W-1:0] presc_q;

         assign unit_done = run_q && tick && (presc_q == PMAX);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                presc_q <= '0;
            else if (clr)              presc_q <= '0;
            else if (arm && !run_q)    presc_q <= '0;
            else if (run_q && tick)    presc_q <= presc_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         units_q <= '0;
      end else if (clr) begin
         run_q   <= 1'b0;
         units_q <= '0;
      end else if (arm && !run_q) begin
         run_q   <= 1'b1;
         units_q <= '0;
      end else if (unit_done) begin
         units_q <= units_nxt[TW-1:0];
      end
   end

endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
   import irq_coal_pkg::*;
#(
   parameter int                PRESC_W  = 6,
   parameter bit                RST_EN   = 1'b1,
   parameter logic [CNT_W-1:0]  RST_CNT  = 8'd16,
   parameter logic [TIME_W-1:0] RST_TIME = 16'd768
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             frame_done,
   input  logic             if_tick,
   input  logic             irq_ack,
   output logic             irq
);

   generate
      if (PRESC_W < 0 || PRESC_W > 16) begin : g_bad_presc
         $error("irq_coalesce: PRESC_W must be within 0..16");
      end
      if (CNT_LSB + CNT_W > TIME_LSB && CNT_LSB < TIME_LSB + TIME_W) begin : g_bad_fields
         $error("irq_coalesce: count and time fields overlap");
      end
   endgenerate

   coal_cfg_t         cfg;
   logic              active;
   logic [CNT_W-1:0]  fcnt;
   logic              cnt_hit;
   logic              tmr_run;
   logic              tmr_exp;
   logic              fire;
   logic              win_clr;
   logic              irq_q;

   irq_coal_cfg #(
      .RST_EN   (RST_EN),
      .RST_CNT  (RST_CNT),
      .RST_TIME (RST_TIME)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (cfg_wr),
      .wdata  (cfg_wdata),
      .cfg    (cfg),
      .active (active)
   );

   assign fire    = active ? (cnt_hit || tmr_exp) : frame_done;
   assign win_clr = fire || cfg_wr || !active;

   irq_coal_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (win_clr),
      .inc   (frame_done && active),
      .thr   (cfg.cnt_thr),
      .cnt   (fcnt),
      .hit   (cnt_hit)
   );

   irq_coal_timer #(.TW(TIME_W), .PRESC_W(PRESC_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (win_clr),
      .arm     (frame_done && active),
      .tick    (if_tick),
      .thr     (cfg.time_thr),
      .running (tmr_run),
      .expire  (tmr_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (fire)    irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
   end

   assign irq = irq_q;

endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk
   import irq_coal_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic             frame_done,
   input logic             irq_ack,
   input logic             irq,
   input logic             fire,
   input logic             active,
   input logic [CNT_W-1:0] fcnt,
   input logic [CNT_W-1:0] cnt_thr,
   input logic             tmr_run
);

   assert_fire_sets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> irq);

   assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !fire) |=> !irq);

   assert_bypass_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && frame_done) |=> irq);

   assert_count_below_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (fcnt < cnt_thr));

   assert_fire_clears_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (fcnt == '0 && !tmr_run));

   assert_cfg_clears_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (fcnt == '0 && !tmr_run));

   assert_timer_needs_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_run) |-> $past(frame_done));

endmodule

bind irq_coalesce irq_coalesce_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .frame_done (frame_done),
   .irq_ack    (irq_ack),
   .irq        (irq),
   .fire       (fire),
   .active     (active),
   .fcnt       (fcnt),
   .cnt_thr    (cfg.cnt_thr),
   .tmr_run    (tmr_run)
);

// File: tb/irq_coalesce_test.sv
module irq_coalesce_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        frame_done = 1'b0;
   logic        if_tick = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_coalesce uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_wdata  (cfg_wdata),
      .frame_done (frame_done),
      .if_tick    (if_tick),
      .irq_ack    (irq_ack),
      .irq        (irq)
   );

   // {config word, frame count, expected irq}
   localparam logic [40:0] VEC [9] = '{
      {1'b1, 2'b0, 8'd4,   5'b0, 16'd100, 8'd3,   1'b0},
      {1'b1, 2'b0, 8'd4,   5'b0, 16'd100, 8'd4,   1'b1},
      {1'b0, 2'b0, 8'd4,   5'b0, 16'd100, 8'd1,   1'b1},
      {1'b1, 2'b0, 8'd0,   5'b0, 16'd100, 8'd1,   1'b1},
      {1'b1, 2'b0, 8'd5,   5'b0, 16'd0,   8'd1,   1'b1},
      {1'b1, 2'b0, 8'd1,   5'b0, 16'd100, 8'd1,   1'b1},
      {1'b1, 2'b0, 8'd255, 5'b0, 16'd100, 8'd254, 1'b0},
      {1'b1, 2'b0, 8'd255, 5'b0, 16'd100, 8'd255, 1'b1},
      {1'b1, 2'b1, 8'd2,   5'b1, 16'd5,   8'd1,   1'b0}
   };

   function automatic logic [31:0] mkcfg(input bit en, input int cnt, input int tm);
      return {en, 2'b00, 8'(cnt), 5'b0, 16'(tm)};
   endfunction

   task automatic step(input bit fd, input bit tk, input bit ak);
      frame_done = fd;
      if_tick    = tk;
      irq_ack    = ak;
      @(posedge clk);
      @(negedge clk);
      frame_done = 1'b0;
      if_tick    = 1'b0;
      irq_ack    = 1'b0;
   endtask

   task automatic wcfg(input logic [31:0] w);
      cfg_wr    = 1'b1;
      cfg_wdata = w;
      @(posedge clk);
      @(negedge clk);
      cfg_wr    = 1'b0;
   endtask

   task automatic check(input string req, input logic exp);
      checks++;
      if (irq !== exp) begin
         errors++;
         $display("FAIL %s: irq=%b expected %b", req, irq, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", 1'b0);

      // R1: reset defaults, count 16
      for (int i = 0; i < 15; i++) step(1, 0, 0);
      check("R1 15 frames", 1'b0);
      step(1, 0, 0);
      check("R1 16th frame", 1'b1);
      step(0, 0, 1);
      check("R7 ack clears", 1'b0);

      // R2 R3 R4 R10: table walk, no ticks
      for (int v = 0; v < 9; v++) begin
         wcfg(VEC[v][40:9]);
         step(0, 0, 1);
         for (int f = 0; f < int'(VEC[v][8:1]); f++) step(1, 0, 0);
         check($sformatf("R2 R3 R4 R10 vector %0d", v), VEC[v][0]);
         step(0, 0, 1);
      end

      // R11: ticks alone never fire
      wcfg(mkcfg(1, 100, 2));
      for (int i = 0; i < 300; i++) step(0, 1, 0);
      check("R11 idle ticks", 1'b0);

      // R5: time expiry counted in gated ticks
      step(1, 0, 0);
      for (int i = 0; i < 127; i++) begin
         step(0, 1, 0);
         step(0, 0, 0);
      end
      check("R5 tick 127", 1'b0);
      step(0, 1, 0);
      check("R5 tick 128", 1'b1);

      // R7: held without ack
      for (int i = 0; i < 10; i++) step(0, 1, 0);
      check("R7 held", 1'b1);
      step(0, 0, 1);
      check("R7 ack", 1'b0);

      // R6: count hit first, then window restarts from zero
      wcfg(mkcfg(1, 3, 2));
      step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
      check("R6 count first", 1'b1);
      step(0, 0, 1);
      step(1, 0, 0); step(1, 0, 0);
      check("R6 count cleared", 1'b0);

      // R6: timer first clears count
      wcfg(mkcfg(1, 3, 1));
      step(0, 0, 1);
      step(1, 0, 0); step(1, 0, 0);
      for (int i = 0; i < 63; i++) step(0, 1, 0);
      check("R6 timer 63", 1'b0);
      step(0, 1, 0);
      check("R6 timer first", 1'b1);
      step(0, 0, 1);
      step(1, 0, 0); step(1, 0, 0);
      check("R6 count restarted", 1'b0);
      step(1, 0, 0);
      check("R6 third frame", 1'b1);
      step(0, 0, 1);

      // R8: events while pending start a new window
      wcfg(mkcfg(1, 2, 1000));
      step(1, 0, 0); step(1, 0, 0);
      check("R8 fire", 1'b1);
      step(1, 0, 0);
      step(0, 0, 1);
      check("R8 ack", 1'b0);
      step(1, 0, 0);
      check("R8 new window", 1'b1);
      step(0, 0, 1);

      // R7: fire in the ack cycle keeps irq set (bypass)
      wcfg(mkcfg(0, 2, 10));
      step(1, 0, 0);
      step(1, 0, 1);
      check("R7 ack with fire", 1'b1);
      step(0, 0, 1);

      // R9: config write clears count
      wcfg(mkcfg(1, 3, 1000));
      step(1, 0, 0); step(1, 0, 0);
      wcfg(mkcfg(1, 3, 1000));
      step(1, 0, 0);
      check("R9 count cleared", 1'b0);
      step(1, 0, 0); step(1, 0, 0);
      check("R9 recount", 1'b1);
      step(0, 0, 1);

      // R9: config write stops the timer
      wcfg(mkcfg(1, 10, 1));
      step(1, 0, 0);
      for (int i = 0; i < 40; i++) step(0, 1, 0);
      wcfg(mkcfg(1, 10, 1));
      for (int i = 0; i < 100; i++) step(0, 1, 0);
      check("R9 timer stopped", 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule